// File: doc/BRIEF.md
# PWM Duty Readback to Brightness Converter

This unit takes the fields that program a backlight PWM (a period, a bit-count that sets how many period bits are meaningful, a 16-bit active-duty count and a flag that selects fractional duty resolution) and works back from them to a normalized 16-bit brightness value. It is used when the brightness that the hardware is currently producing has to be recovered from the PWM settings alone, for instance to seed a brightness controller after power-up.

A `start` pulse captures the four fields. The unit masks them, runs a restoring divider that produces one quotient bit per clock, rounds the quotient to half, multiplies it back by the period and rounds once more on the way out. The result is presented on `level` together with a one-cycle `done` pulse, a fixed number of clocks after `start`.

The control FSM has five states. IDLE waits for `start` (IDLE to PREP on start, otherwise stay). PREP masks the captured fields and loads the divider (PREP to DIV always). DIV performs one divide step per clock (DIV to SCALE after the last quotient bit, otherwise stay). SCALE forms the product of the halved quotient and the period (SCALE to FINISH always). FINISH applies the final shift and rounding, updates `level` and pulses `done` (FINISH to IDLE always).

Top module: `pwm_duty_to_level`

## Requirements
- R1: A bit-count field `cnt_fld` of 0 selects a bit-count n of 16; any other value v selects n = v.
- R2: The effective period is `per_fld` with all bits at or above bit n cleared; if that masked value is 0, the effective period is 0xFFFF.
- R3: With `frac_en` low, the duty keeps only bits 15 down to 16−n of `duty_fld` (the low-n-bit mask shifted left by 16−n); the other duty bits are cleared.
- R4: With `frac_en` high, all 16 bits of `duty_fld` are used.
- R5: With D the masked duty and P the effective period: q = floor(D·2^(n+1) / P), h = (q+1)>>1, X = h·P, and `level` = ((X >> n) + bit (n−1) of X) modulo 2^16.
- R6: `done` is high for exactly one cycle, asserted by the 37th rising edge after the edge that samples `start` high in IDLE; it is low at every other time.
- R7: The fields are captured on the edge that accepts `start`; changing them afterwards has no effect on the result.
- R8: A `start` seen while a conversion is in progress (any state other than IDLE) is ignored and produces no extra `done`.
- R9: During and right after reset, `done` is 0 and `level` is 0.
- R10: `level` changes only together with `done` and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (accepted only in IDLE) |
| per_fld | input | 16 | Programmed PWM period |
| cnt_fld | input | 4 | Period bit-count, 0 means 16 |
| duty_fld | input | 16 | Programmed active duty count |
| frac_en | input | 1 | Fractional duty resolution enable |
| level | output | 16 | Recovered brightness |
| done | output | 1 | One-cycle pulse when `level` is updated |

## Verification
The hardest situation to reach from the ports is a `start` arriving mid-conversion with different field values, combined with field changes after capture: both must leave the result and the `done` timing untouched. The stimulus pulses `start` again a few cycles into a conversion with other fields and scrambles the fields right after capture, while a behavioural model that tracks only accepted starts is compared against `done` and `level` on every clock. Masked-period-zero, bit-count zero and both duty-mask modes are driven by directed vectors before a stream of random fields.

// File: rtl/pwmrb_pkg.sv
package pwmrb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_DIV,
        S_SCALE,
        S_FINISH
    } pwmrb_state_e;

endpackage

// File: rtl/pwmrb_mask.sv
module pwmrb_mask #(
    parameter int PER_W = 16,
    parameter int CNT_W = 4,
    parameter int NUM_W = 34
) (
    input  logic [PER_W-1:0] per_fld,
    input  logic [CNT_W-1:0] cnt_fld,
    input  logic [PER_W-1:0] duty_fld,
    input  logic             frac_en,
    output logic [CNT_W:0]   nbits,
    output logic [PER_W-1:0] per_eff,
    output logic [NUM_W-1:0] num
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(PER_W);

    logic [PER_W-1:0] pmask;
    logic [PER_W-1:0] pm;
    logic [PER_W-1:0] dmask;

    always_comb begin
        nbits   = (cnt_fld == '0) ? FULL : {1'b0, cnt_fld};
        pmask   = {PER_W{1'b1}} >> (FULL - nbits);
        pm      = per_fld & pmask;
        per_eff = (pm == '0) ? {PER_W{1'b1}} : pm;
        dmask   = frac_en ? {PER_W{1'b1}} : (pmask << (FULL - nbits));
        num     = NUM_W'(duty_fld & dmask) << (nbits + (CNT_W+1)'(1));
    end

endmodule

// File: rtl/pwmrb_divider.sv
module pwmrb_divider #(
    parameter int NUM_W = 34,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [NUM_W-1:0] num,
    input  logic [PER_W-1:0] den,
    output logic [NUM_W-1:0] quo
);
    logic [NUM_W-1:0] nq;
    logic [PER_W-1:0] rem;
    logic [PER_W:0]   trial;
    logic [PER_W:0]   diff;
    logic             ge;

    always_comb begin
        trial = {rem, nq[NUM_W-1]};
        ge    = trial >= {1'b0, den};
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nq  <= '0;
            rem <= '0;
        end else if (load) begin
            nq  <= num;
            rem <= '0;
        end else if (step) begin
            nq  <= {nq[NUM_W-2:0], ge};
            rem <= ge ? diff[PER_W-1:0] : trial[PER_W-1:0];
        end
    end

    assign quo = nq;

    // R5: partial remainder always stays below the divisor
    p_rem_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem < den));

endmodule

// File: rtl/pwmrb_rescale.sv
module pwmrb_rescale #(
    parameter int NUM_W  = 34,
    parameter int PER_W  = 16,
    parameter int CNT_W  = 4,
    parameter int PROD_W = 50
) (
    input  logic [NUM_W-1:0]  quo,
    input  logic [PER_W-1:0]  per,
    input  logic [PROD_W-1:0] prod_q,
    input  logic [CNT_W:0]    nbits,
    output logic [PROD_W-1:0] prod,
    output logic [PER_W-1:0]  level_nx
);
    logic [NUM_W-1:0]  half;
    logic [PROD_W-1:0] tail;

    always_comb begin
        half     = (quo + NUM_W'(1)) >> 1;
        prod     = PROD_W'(half) * PROD_W'(per);
        tail     = prod_q >> (nbits - (CNT_W+1)'(1));
        level_nx = PER_W'(tail >> 1) + PER_W'(tail[0]);
    end

endmodule

// File: rtl/pwm_duty_to_level.sv
module pwm_duty_to_level
    import pwmrb_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] per_fld,
    input  logic [CNT_W-1:0] cnt_fld,
    input  logic [PER_W-1:0] duty_fld,
    input  logic             frac_en,
    output logic [PER_W-1:0] level,
    output logic             done
);
    localparam int NUM_W  = 2 * PER_W + 2;
    localparam int PROD_W = NUM_W + PER_W;
    localparam int STEP_W = $clog2(NUM_W);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_W - 1);

    pwmrb_state_e st, st_nx;

    logic [PER_W-1:0]  per_cap, duty_cap, per_q;
    logic [CNT_W-1:0]  cnt_cap;
    logic              frac_cap;
    logic [CNT_W:0]    nbits, nbits_q;
    logic [PER_W-1:0]  per_eff;
    logic [NUM_W-1:0]  num, quo;
    logic [PROD_W-1:0] prod, prod_q;
    logic [PER_W-1:0]  level_nx;
    logic [STEP_W-1:0] step_cnt;

    pwmrb_mask #(.PER_W(PER_W), .CNT_W(CNT_W), .NUM_W(NUM_W)) u_mask (
        .per_fld (per_cap),
        .cnt_fld (cnt_cap),
        .duty_fld(duty_cap),
        .frac_en (frac_cap),
        .nbits   (nbits),
        .per_eff (per_eff),
        .num     (num)
    );

    pwmrb_divider #(.NUM_W(NUM_W), .PER_W(PER_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .load (st == S_PREP),
        .step (st == S_DIV),
        .num  (num),
        .den  (per_q),
        .quo  (quo)
    );

    pwmrb_rescale #(.NUM_W(NUM_W), .PER_W(PER_W), .CNT_W(CNT_W), .PROD_W(PROD_W)) u_rescale (
        .quo     (quo),
        .per     (per_q),
        .prod_q  (prod_q),
        .nbits   (nbits_q),
        .prod    (prod),
        .level_nx(level_nx)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = S_PREP;
            S_PREP:   st_nx = S_DIV;
            S_DIV:    if (step_cnt == LAST_STEP) st_nx = S_SCALE;
            S_SCALE:  st_nx = S_FINISH;
            S_FINISH: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cap  <= '0;
            duty_cap <= '0;
            cnt_cap  <= '0;
            frac_cap <= 1'b0;
            per_q    <= '1;
            nbits_q  <= '0;
            prod_q   <= '0;
            step_cnt <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    per_cap  <= per_fld;
                    duty_cap <= duty_fld;
                    cnt_cap  <= cnt_fld;
                    frac_cap <= frac_en;
                end
                S_PREP: begin
                    per_q    <= per_eff;
                    nbits_q  <= nbits;
                    step_cnt <= '0;
                end
                S_DIV:    step_cnt <= step_cnt + STEP_W'(1);
                S_SCALE:  prod_q   <= prod;
                S_FINISH: ;
                default:  ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            done  <= 1'b0;
        end else begin
            done <= (st == S_FINISH);
            if (st == S_FINISH) level <= level_nx;
        end
    end

    // R6: done lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the FSM is back in IDLE when done is seen
    p_done_in_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st == S_IDLE));

    // R8: no new conversion is launched from a busy state
    p_busy_blocks_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> (st != S_PREP));

    // R7: captured duty holds while a conversion runs
    p_fields_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(duty_cap));

    // R10: level only moves with done
    p_level_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> done);

endmodule

// File: tb/test_pwm_duty_to_level.sv
module test_pwm_duty_to_level;

    localparam int LAT = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] per_fld = '0;
    logic [3:0]  cnt_fld = '0;
    logic [15:0] duty_fld = '0;
    logic        frac_en = 1'b0;
    logic [15:0] level;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit mon_en = 0;

    always #5 clk = ~clk;

    pwm_duty_to_level i_pwm_duty_to_level (
        .clk(clk), .rst_n(rst_n), .start(start), .per_fld(per_fld),
        .cnt_fld(cnt_fld), .duty_fld(duty_fld), .frac_en(frac_en),
        .level(level), .done(done)
    );

    function automatic logic [15:0] ref_level(logic [15:0] p, logic [3:0] c, logic [15:0] d, logic f);
        longint n, pm, per, dm, num, q, h, x, r;
        n   = (c == 0) ? 16 : longint'(c);
        pm  = (64'd1 << n) - 1;
        per = longint'(p) & pm;
        if (per == 0) per = 65535;
        dm  = f ? 65535 : ((pm << (16 - n)) & 65535);
        num = (longint'(d) & dm) << (n + 1);
        q   = num / per;
        h   = (q + 1) >> 1;
        x   = h * per;
        r   = (x >> n) + ((x >> (n - 1)) & 1);
        return 16'(r);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // behavioural reference, one step per clock
    int          busy_m = 0;
    logic        exp_done = 1'b0;
    logic [15:0] exp_level = '0;
    logic [15:0] pend = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m = 0; exp_done = 1'b0; exp_level = '0;
        end else begin
            exp_done = 1'b0;
            if (busy_m > 0) begin
                busy_m--;
                if (busy_m == 0) begin
                    exp_done = 1'b1;
                    exp_level = pend;
                end
            end else if (start) begin
                busy_m = LAT;
                pend = ref_level(per_fld, cnt_fld, duty_fld, frac_en);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            check(done === exp_done, "R6 done timing", 32'(done), 32'(exp_done));
            check(level === exp_level, "R10 level hold", 32'(level), 32'(exp_level));
        end
    end

    task automatic run_case(logic [15:0] p, logic [3:0] c, logic [15:0] d, logic f,
                            string tag, bit scramble, bit poke);
        logic [15:0] want;
        bit seen;
        want = ref_level(p, c, d, f);
        @(negedge clk);
        per_fld = p; cnt_fld = c; duty_fld = d; frac_en = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            per_fld = ~p; cnt_fld = c + 4'd3; duty_fld = ~d; frac_en = ~f;
        end
        if (poke) begin
            repeat (4) @(negedge clk);
            per_fld = 16'h0007; cnt_fld = 4'd3; duty_fld = 16'hE000; frac_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0;
        for (int i = 0; i < LAT + 4 && !seen; i++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check(seen, {tag, " done seen"}, 32'(seen), 32'd1);
        check(level === want, tag, 32'(level), 32'(want));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R9 done in reset", 32'(done), 32'd0);
        check(level === 16'h0, "R9 level in reset", 32'(level), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0, "R9 done after reset", 32'(done), 32'd0);
        check(level === 16'h0, "R9 level after reset", 32'(level), 32'd0);
        mon_en = 1;

        run_case(16'h1234, 4'd0, 16'hABCD, 1'b0, "R1 count zero is 16", 0, 0);
        run_case(16'hFFFF, 4'd0, 16'hFFFF, 1'b0, "R1 full scale", 0, 0);
        run_case(16'hFF00, 4'd8, 16'h8000, 1'b0, "R2 masked period zero", 0, 0);
        run_case(16'hFFA4, 4'd6, 16'h5555, 1'b0, "R2 period high bits cleared", 0, 0);
        run_case(16'h0024, 4'd6, 16'hFFFF, 1'b0, "R3 coarse duty mask", 0, 0);
        run_case(16'h0024, 4'd6, 16'h03FF, 1'b0, "R3 low duty bits dropped", 0, 0);
        run_case(16'h0024, 4'd6, 16'hFFFF, 1'b1, "R4 fractional duty", 0, 0);
        run_case(16'h0024, 4'd6, 16'h03FF, 1'b1, "R4 fractional low bits", 0, 0);
        run_case(16'h0001, 4'd1, 16'h8000, 1'b0, "R5 one-bit period", 0, 0);
        run_case(16'h0FA0, 4'd12, 16'h0000, 1'b0, "R5 zero duty", 0, 0);
        run_case(16'h0FA0, 4'd12, 16'hFA00, 1'b1, "R5 typical", 0, 0);
        run_case(16'h00C3, 4'd8, 16'h7E11, 1'b1, "R7 fields changed after capture", 1, 0);
        run_case(16'h3A5C, 4'd15, 16'h9ABC, 1'b0, "R8 start while busy", 0, 1);

        for (int k = 0; k < 40; k++) begin
            run_case(16'($urandom), 4'($urandom), 16'($urandom), 1'($urandom),
                     "R5 random", 0, 0);
        end

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule